// File: doc/BRIEF.md
# Watchdog Timer with Paired Pre-Clear

This block is a free-running supervision timer. Each `tick_i` pulse advances a fixed frequency divider. The divider's carry drives a prescaler, and the prescaler's carry drives the timeout counter. When the counter passes a power-of-two limit chosen by a static exponent select, the block raises a one-cycle pulse.

The kind of pulse depends on the halt input. While the core runs, the pulse is a reset request. While the core is halted, the pulse is a wakeup. Either pulse sets a sticky time-out flag.

Firmware keeps the timer from expiring with clear strobes. A mode input selects how those strobes are accepted. In single mode, one clear strobe is enough. In pair mode, two different pre-clear strobes must both arrive, in either order, and only then do the counters restart.

Top module: `wdt_preclear`

## Requirements
- R1: With `tick_i` high on every cycle, the first timeout comes on exactly tick 2^(DIV_W+PRE_W+MIN_EXP+sel_i) after a clear. `sel_i` is 2 bits and picks exponent 8+`sel_i`. The defaults (DIV_W=1, PRE_W=1) give 1024, 2048, 4096 and 8192 ticks.
- R2: Cycles with `tick_i` low do not advance the divider, the prescaler or the counter.
- R3: While `en_i` is low, no pulse is produced and all stages are held at zero. After re-enabling, a full period from zero is needed before the next timeout.
- R4: A timeout with `halt_i` low gives `rst_req_o` high for exactly one cycle, in the cycle after the final tick's clock edge, with `wake_o` low.
- R5: A timeout with `halt_i` high gives `wake_o` high for exactly one cycle at the same point, with `rst_req_o` low.
- R6: `to_flag_o` is 0 after reset. It rises together with either pulse and stays high until a clear is accepted.
- R7: In single mode (`mode_i`=0), `clr_i` zeroes the divider, prescaler and counter and drops `to_flag_o`.
- R8: In single mode, `pre1_i` and `pre2_i` have no effect on timing or on `to_flag_o`.
- R9: In pair mode (`mode_i`=1), a clear is accepted in the cycle by which both `pre1_i` and `pre2_i` have been seen, in either order or together. It has the same effect as R7. A single pre-clear alone changes nothing.
- R10: In pair mode, `clr_i` has no effect.
- R11: A half-received pre-clear pair is forgotten on a timeout and after each accepted clear.
- R12: A clear accepted on the same cycle as the final tick wins: no pulse is produced, and the next timeout needs a full period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| tick_i | input | 1 | Watchdog clock enable |
| en_i | input | 1 | Static watchdog enable |
| sel_i | input | 2 | Timeout exponent select (8+sel_i) |
| mode_i | input | 1 | 0 single clear, 1 pre-clear pair |
| halt_i | input | 1 | Core halted |
| clr_i | input | 1 | Single clear command strobe |
| pre1_i | input | 1 | First pre-clear command strobe |
| pre2_i | input | 1 | Second pre-clear command strobe |
| rst_req_o | output | 1 | Timeout reset request pulse |
| wake_o | output | 1 | Timeout wakeup pulse while halted |
| to_flag_o | output | 1 | Sticky time-out flag |

## Verification
The period is measured at all four exponent selections with a continuous tick, and once with a tick on every other cycle. An off-by-one in any stage, or a stage that counts idle cycles, therefore shows up as a wrong tick index.

Clears are applied one tick short of expiry and on the expiring tick itself. These cases separate a clear that truly zeroes the divider and prescaler from one that only resets the counter, and show which side wins at the boundary.

Pre-clear strobes are sent in each order, together, alone, and across an intervening timeout. Each of these patterns then leaves a distinct remaining time to the next pulse, so a stale half-pair or a wrongly ignored strobe becomes visible.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic {
    WDT_CLR_SINGLE = 1'b0,
    WDT_CLR_PAIR   = 1'b1
  } wdt_clr_mode_e;

  typedef struct packed {
    logic first;
    logic second;
  } wdt_pre_t;
endpackage

// File: rtl/wdt_pow2_div.sv
module wdt_pow2_div #(
  parameter int W = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  output logic carry_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= '0;
    else if (clr_i)  q_q <= '0;
    else if (tick_i) q_q <= q_q + W'(1);
  end

  assign carry_o = tick_i & (&q_q) & ~clr_i;
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int MIN_EXP = 8,
  parameter int SEL_W   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             step_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             to_evt_o
);
  localparam int CNT_W = MIN_EXP + (2 ** SEL_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  int               exp_sel;

  always_comb begin
    exp_sel = MIN_EXP + int'(sel_i);
    for (int b = 0; b < CNT_W; b++) limit[b] = (b < exp_sel);
  end

  // clear beats the last step
  assign to_evt_o = en_i & step_i & ~clr_i & (cnt_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!en_i || clr_i)  cnt_q <= '0;
    else if (to_evt_o)        cnt_q <= '0;
    else if (step_i)          cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/wdt_clear_ctrl.sv
module wdt_clear_ctrl
  import wdt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic mode_i,
  input  logic clr_i,
  input  logic pre1_i,
  input  logic pre2_i,
  input  logic to_evt_i,
  output logic clear_o
);
  wdt_pre_t      seen_q, seen_d;
  wdt_clr_mode_e mode;

  assign mode = wdt_clr_mode_e'(mode_i);

  always_comb begin
    seen_d.first  = seen_q.first  | pre1_i;
    seen_d.second = seen_q.second | pre2_i;
  end

  assign clear_o = (mode == WDT_CLR_PAIR) ? (seen_d.first & seen_d.second) : clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      seen_q <= '0;
    else if (!en_i || mode != WDT_CLR_PAIR || clear_o || to_evt_i)
      seen_q <= '0;
    else
      seen_q <= seen_d;
  end
endmodule

// File: rtl/wdt_preclear.sv
module wdt_preclear #(
  parameter int DIV_W   = 1,
  parameter int PRE_W   = 1,
  parameter int MIN_EXP = 8,
  parameter int SEL_W   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             mode_i,
  input  logic             halt_i,
  input  logic             clr_i,
  input  logic             pre1_i,
  input  logic             pre2_i,
  output logic             rst_req_o,
  output logic             wake_o,
  output logic             to_flag_o
);
  logic clear, hold_zero, div_carry, pre_carry, to_evt;

  assign hold_zero = ~en_i | clear;

  wdt_clear_ctrl u_clr (
    .clk_i, .rst_ni, .en_i, .mode_i, .clr_i, .pre1_i, .pre2_i,
    .to_evt_i(to_evt), .clear_o(clear)
  );

  wdt_pow2_div #(.W(DIV_W)) u_div (
    .clk_i, .rst_ni, .tick_i(tick_i), .clr_i(hold_zero), .carry_o(div_carry)
  );

  wdt_pow2_div #(.W(PRE_W)) u_pre (
    .clk_i, .rst_ni, .tick_i(div_carry), .clr_i(hold_zero), .carry_o(pre_carry)
  );

  wdt_count #(.MIN_EXP(MIN_EXP), .SEL_W(SEL_W)) u_cnt (
    .clk_i, .rst_ni, .en_i, .step_i(pre_carry), .clr_i(clear), .sel_i,
    .to_evt_o(to_evt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_req_o <= 1'b0;
      wake_o    <= 1'b0;
      to_flag_o <= 1'b0;
    end else begin
      rst_req_o <= to_evt & ~halt_i;
      wake_o    <= to_evt & halt_i;
      if (to_evt)     to_flag_o <= 1'b1;
      else if (clear) to_flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/wdt_preclear_chk.sv
module wdt_preclear_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic mode_i,
  input logic halt_i,
  input logic clr_i,
  input logic pre1_i,
  input logic pre2_i,
  input logic rst_req_o,
  input logic wake_o,
  input logic to_flag_o
);
  p_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rst_req_o && wake_o));
  p_rst_narrow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
  p_wake_narrow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);
  p_rst_running_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> !$past(halt_i));
  p_wake_halted_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(halt_i));
  p_off_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !(rst_req_o || wake_o));
  p_flag_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_req_o || wake_o) |-> to_flag_o);
  p_single_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && clr_i) |=> !to_flag_o);
  p_pair_noclr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && clr_i && !pre1_i && !pre2_i && to_flag_o) |=> to_flag_o);
endmodule

bind wdt_preclear wdt_preclear_chk u_chk (
  .clk_i, .rst_ni, .en_i, .mode_i, .halt_i, .clr_i, .pre1_i, .pre2_i,
  .rst_req_o, .wake_o, .to_flag_o
);

// File: tb/wdt_preclear_bench.sv
module wdt_preclear_bench;
  localparam int PS_W = 2;
  localparam int MIN_EXP = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, en = 1, halt = 0, mode = 0, clr = 0, p1 = 0, p2 = 0;
  logic [1:0] sel = '0;
  logic rst_req, wake, flag;
  int errs = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wdt_preclear u_wdt_preclear (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .en_i(en), .sel_i(sel),
    .mode_i(mode), .halt_i(halt), .clr_i(clr), .pre1_i(p1), .pre2_i(p2),
    .rst_req_o(rst_req), .wake_o(wake), .to_flag_o(flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int period(input int s);
    return 1 << (PS_W + MIN_EXP + s);
  endfunction

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1; @(negedge clk); tick = 0;
    end
  endtask

  // 1 clr, 2 pre1, 3 pre2, 4 both pre
  task automatic cmd(input int which);
    clr = (which == 1); p1 = (which == 2 || which == 4); p2 = (which == 3 || which == 4);
    @(negedge clk);
    clr = 0; p1 = 0; p2 = 0;
  endtask

  task automatic measure(input int maxt, input bit gap, output int idx,
                         output bit s_rst, output bit s_wake, output bit wide);
    idx = 0; s_rst = 0; s_wake = 0; wide = 0;
    for (int i = 1; i <= maxt; i++) begin
      tick = 1; @(negedge clk); tick = 0;
      if (rst_req || wake) begin
        idx = i; s_rst = rst_req; s_wake = wake;
        @(negedge clk);
        if (rst_req || wake) wide = 1;
        break;
      end
      if (gap) @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int idx, k;
    bit sr, sw, wd;
    repeat (3) @(negedge clk);
    chk(!flag, "R6 reset flag", flag, 0);
    chk(!rst_req, "R4 reset pulse", rst_req, 0);
    chk(!wake, "R5 reset wake", wake, 0);
    rst_n = 1; @(negedge clk);

    for (int s = 0; s < 4; s++) begin
      sel = 2'(s); cmd(1);
      measure(period(s) + 4, 0, idx, sr, sw, wd);
      chk(idx == period(s), "R1 period", idx, period(s));
      chk(sr && !sw, "R4 reset kind", {sr, sw}, 2);
      chk(!wd, "R4 width", wd, 0);
      chk(flag, "R6 set", flag, 1);
    end

    sel = 0; k = period(0);
    cmd(1);
    measure(k + 4, 1, idx, sr, sw, wd);
    chk(idx == k, "R2 gapped ticks", idx, k);

    halt = 1; cmd(1);
    measure(k + 4, 0, idx, sr, sw, wd);
    chk(idx == k, "R5 period", idx, k);
    chk(sw && !sr, "R5 wake kind", {sr, sw}, 1);
    chk(!wd, "R5 width", wd, 0);
    chk(flag, "R6 set halted", flag, 1);
    halt = 0;
    run(10);
    chk(flag, "R6 sticky", flag, 1);

    cmd(1);
    chk(!flag, "R7 flag cleared", flag, 0);
    run(k - 1); cmd(1);
    measure(k + 4, 0, idx, sr, sw, wd);
    chk(idx == k, "R7 clear restarts", idx, k);

    cmd(1); run(k - 1);
    tick = 1; clr = 1; @(negedge clk); tick = 0; clr = 0;
    chk(!rst_req && !wake, "R12 no pulse", rst_req, 0);
    chk(!flag, "R12 flag", flag, 0);
    measure(k + 4, 0, idx, sr, sw, wd);
    chk(idx == k, "R12 full period", idx, k);

    run(k / 2); cmd(2); cmd(3); cmd(4);
    chk(flag, "R8 flag kept", flag, 1);
    measure(k + 4, 0, idx, sr, sw, wd);
    chk(idx == k / 2, "R8 pre ignored", idx, k / 2);

    mode = 1;
    run(k / 2); cmd(1);
    chk(flag, "R10 flag kept", flag, 1);
    measure(k + 4, 0, idx, sr, sw, wd);
    chk(idx == k / 2, "R10 clr ignored", idx, k / 2);

    run(k / 2); cmd(2);
    chk(flag, "R9 half pair", flag, 1);
    run(k / 4); cmd(3);
    chk(!flag, "R9 pair clears flag", flag, 0);
    measure(k + 4, 0, idx, sr, sw, wd);
    chk(idx == k, "R9 order 1-2", idx, k);
    run(k / 2); cmd(3); run(k / 4); cmd(2);
    measure(k + 4, 0, idx, sr, sw, wd);
    chk(idx == k, "R9 order 2-1", idx, k);
    run(k / 2); cmd(4);
    measure(k + 4, 0, idx, sr, sw, wd);
    chk(idx == k, "R9 same cycle", idx, k);

    cmd(2);
    measure(k + 4, 0, idx, sr, sw, wd);
    chk(idx == k, "R9 single pre no clear", idx, k);
    run(k / 2); cmd(3);
    measure(k + 4, 0, idx, sr, sw, wd);
    chk(idx == k / 2, "R11 stale after timeout", idx, k / 2);
    cmd(2); run(10); cmd(3);
    run(k / 2); cmd(3);
    measure(k + 4, 0, idx, sr, sw, wd);
    chk(idx == k / 2, "R11 stale after clear", idx, k / 2);

    mode = 0; cmd(1);
    run(k / 2); en = 0;
    measure(2 * k, 0, idx, sr, sw, wd);
    chk(idx == 0, "R3 disabled quiet", idx, 0);
    en = 1;
    measure(k + 4, 0, idx, sr, sw, wd);
    chk(idx == k, "R3 restart from zero", idx, k);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule